// File: doc/BRIEF.md
# Phase-Cut Dimmer Type Classifier

This block decides how the input line of a solid-state lighting controller is switched. The possibilities are a plain switch, a leading-edge phase-cut dimmer or a trailing-edge phase-cut dimmer. Upstream comparators deliver one observation per line cycle. A boundary strobe marks the end of each cycle. With the strobe come two flags: one says the rising side of the waveform showed a phase-cut step, the other says the falling side showed a steep trailing slope. A supply-ready level tells the block that the undervoltage lockout has released.

After the supply becomes ready, the block first spends two line cycles learning and picks one of three operating modes. It then enters a checking phase. In that phase it periodically compares a single cycle's evidence against the chosen mode. The outcome of each comparison feeds a small saturating vote counter, so an isolated bad cycle cannot flip the decision. When enough disagreement builds up, the block goes back to learning. The selected mode stays on the output throughout relearning and changes only when a learn phase completes.

Top module: `dimmer_classifier`

## Requirements
- R1: A synchronous active-low reset puts `phase` at 0 (idle) and `mode` at 0 (no dimmer). Phase codes are 0 idle, 1 learn, 2 check. Mode codes are 0 no dimmer, 1 leading edge, 2 trailing edge.
- R2: While `uvlo_ok` is low the block stays idle. If `uvlo_ok` falls in any phase, `phase` reads 0 after the next clock edge and `mode` keeps its value.
- R3: In idle with `uvlo_ok` high, `phase` becomes 1 after the next clock edge. Strobes seen while idle have no effect on the later learn result.
- R4: A learn phase consumes exactly two `cyc_stb` pulses. On the clock edge of the second pulse, `phase` becomes 2 and `mode` is loaded. Clocks without a strobe do not advance learning.
- R5: The learned mode is 2 if `fall_steep` was high on both learn strobes. Otherwise it is 1 if `rise_cut` was high on both. Otherwise it is 0. Trailing wins when both flags hold on both strobes.
- R6: In the check phase, every 16th strobe is a check cycle. That cycle's evidence reads as 2 if `fall_steep` is high, else 1 if `rise_cut` is high, else 0, and it is compared with `mode`.
- R7: A vote counter runs from 0 to 7. It rises by one on a mismatching check and falls by one on a matching check, stopping at 0. The check that brings it to 7 moves `phase` to 1 on that clock edge. The counter and the period count restart on each new check phase.
- R8: `mode` changes only on the clock edge that ends a learn phase. It holds through relearning and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uvlo_ok | input | 1 | Supply above the start threshold |
| cyc_stb | input | 1 | One-clock pulse at each line-cycle boundary |
| rise_cut | input | 1 | Rising side showed a phase-cut step this cycle |
| fall_steep | input | 1 | Falling side showed a steep trailing slope this cycle |
| mode | output | 2 | Selected operating mode (0 none, 1 leading, 2 trailing) |
| phase | output | 2 | 0 idle, 1 learn, 2 check |

## Verification
A wrong learn counter or a wrong flag accumulator shows up at the second learn strobe. It appears as a premature or late move to phase 2, or as a wrong mode code, one clock after the strobe. A wrong period count or vote counter is slower to show. It appears as a relearn that fires one check period early or late, or not at all, and this becomes visible only after up to seven periods of 16 strobes. The bench therefore drives exact runs of six and seven mismatching checks, with matching checks between them.

// File: rtl/dimclass_pkg.sv
package dimclass_pkg;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_LEAD  = 2'd1,
        MODE_TRAIL = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEARN = 2'd1,
        PH_CHECK = 2'd2
    } phase_e;

    // Evidence of a single cycle: a steep fall outranks a rising cut.
    function automatic mode_e cycle_class(input logic steep, input logic cut);
        if (steep)
            return MODE_TRAIL;
        else if (cut)
            return MODE_LEAD;
        else
            return MODE_NONE;
    endfunction

endpackage

// File: rtl/learn_accum.sv
module learn_accum
    import dimclass_pkg::*;
#(
    parameter int LEARN_CYCLES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  stb,
    input  logic  steep,
    input  logic  cut,
    output logic  done,
    output mode_e verdict
);
    localparam int CW = (LEARN_CYCLES > 1) ? $clog2(LEARN_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEARN_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          all_steep;
        logic          all_cut;
    } acc_t;

    localparam acc_t ACC_INIT = '{cnt: '0, all_steep: 1'b1, all_cut: 1'b1};

    acc_t acc_d, acc_q;
    logic and_steep, and_cut;

    always_comb begin
        acc_d     = acc_q;
        done      = 1'b0;
        and_steep = acc_q.all_steep & steep;
        and_cut   = acc_q.all_cut & cut;
        if (and_steep)
            verdict = MODE_TRAIL;
        else if (and_cut)
            verdict = MODE_LEAD;
        else
            verdict = MODE_NONE;

        if (clr) begin
            acc_d = ACC_INIT;
        end else if (stb) begin
            if (acc_q.cnt == LAST) begin
                done  = 1'b1;
                acc_d = ACC_INIT;
            end else begin
                acc_d.cnt       = acc_q.cnt + 1'b1;
                acc_d.all_steep = and_steep;
                acc_d.all_cut   = and_cut;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= ACC_INIT;
        else
            acc_q <= acc_d;
    end

    // R4: the strobe count never passes the last learn cycle
    p_learn_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q.cnt <= LAST);

    // R4: a strobe that does not finish learning advances the count by one
    p_learn_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && stb && acc_q.cnt != LAST) |=> (acc_q.cnt == $past(acc_q.cnt) + 1'b1));

endmodule

// File: rtl/recheck_timer.sv
module recheck_timer #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic fire
);
    localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        fire  = 1'b0;
        if (clr) begin
            tmr_d.cnt = '0;
        end else if (tick) begin
            if (tmr_q.cnt == LAST) begin
                fire      = 1'b1;
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr_q <= '0;
        else
            tmr_q <= tmr_d;
    end

    // R6: the period count stays inside one check period
    p_period_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST);

    // R6: without a tick or clear the count holds
    p_period_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(tmr_q.cnt));

endmodule

// File: rtl/mismatch_filter.sv
module mismatch_filter #(
    parameter int LIMIT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic upd,
    input  logic miss,
    output logic trip
);
    localparam int FW = $clog2(LIMIT + 1);
    localparam logic [FW-1:0] TOP = FW'(LIMIT);

    typedef struct packed {
        logic [FW-1:0] lvl;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        trip  = 1'b0;
        if (clr) begin
            flt_d.lvl = '0;
        end else if (upd) begin
            if (miss) begin
                if (flt_q.lvl != TOP)
                    flt_d.lvl = flt_q.lvl + 1'b1;
                if (flt_q.lvl == TOP - 1'b1)
                    trip = 1'b1;
            end else if (flt_q.lvl != '0) begin
                flt_d.lvl = flt_q.lvl - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            flt_q <= '0;
        else
            flt_q <= flt_d;
    end

    // R7: the vote never leaves its range
    p_vote_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flt_q.lvl <= TOP);

    // R7: a matching check at zero leaves the vote at zero
    p_vote_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && upd && !miss && flt_q.lvl == '0) |=> (flt_q.lvl == '0));

endmodule

// File: rtl/dimmer_classifier.sv
module dimmer_classifier
    import dimclass_pkg::*;
#(
    parameter int LEARN_CYCLES = 2,
    parameter int CHECK_PERIOD = 16,
    parameter int VOTE_LIMIT   = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uvlo_ok,
    input  logic       cyc_stb,
    input  logic       rise_cut,
    input  logic       fall_steep,
    output logic [1:0] mode,
    output logic [1:0] phase
);
    typedef struct packed {
        phase_e ph;
        mode_e  md;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;

    logic  learn_clr, learn_stb, learn_done;
    mode_e learn_verdict;
    logic  tmr_clr, tmr_tick, tmr_fire;
    logic  flt_clr, flt_miss, flt_trip;
    mode_e now_class;

    always_comb begin
        now_class = cycle_class(fall_steep, rise_cut);
        learn_clr = (ctl_q.ph != PH_LEARN);
        learn_stb = cyc_stb && uvlo_ok && (ctl_q.ph == PH_LEARN);
        tmr_clr   = (ctl_q.ph != PH_CHECK);
        tmr_tick  = cyc_stb && uvlo_ok && (ctl_q.ph == PH_CHECK);
        flt_clr   = tmr_clr;
        flt_miss  = (now_class != ctl_q.md);
    end

    learn_accum #(.LEARN_CYCLES(LEARN_CYCLES)) u_learn (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (learn_clr),
        .stb     (learn_stb),
        .steep   (fall_steep),
        .cut     (rise_cut),
        .done    (learn_done),
        .verdict (learn_verdict)
    );

    recheck_timer #(.PERIOD(CHECK_PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tmr_tick),
        .fire  (tmr_fire)
    );

    mismatch_filter #(.LIMIT(VOTE_LIMIT)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flt_clr),
        .upd   (tmr_fire),
        .miss  (flt_miss),
        .trip  (flt_trip)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (!uvlo_ok) begin
            ctl_d.ph = PH_IDLE;
        end else begin
            unique case (ctl_q.ph)
                PH_IDLE:  ctl_d.ph = PH_LEARN;
                PH_LEARN: begin
                    if (learn_done) begin
                        ctl_d.md = learn_verdict;
                        ctl_d.ph = PH_CHECK;
                    end
                end
                PH_CHECK: begin
                    if (flt_trip)
                        ctl_d.ph = PH_LEARN;
                end
                default:  ctl_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.ph <= PH_IDLE;
            ctl_q.md <= MODE_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mode  = ctl_q.md;
    assign phase = ctl_q.ph;

    // R2: losing the supply forces idle on the next edge
    p_supply_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !uvlo_ok |=> (ctl_q.ph == PH_IDLE));

    // R3: a ready supply takes idle into learning
    p_start_learn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_IDLE && uvlo_ok) |=> (ctl_q.ph == PH_LEARN));

    // R4: learning is left only at its end or on supply loss
    p_learn_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_LEARN && uvlo_ok && !learn_done) |=> (ctl_q.ph == PH_LEARN));

    // R5: only the three mode codes appear
    p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.md != 2'd3);

    // R7: a tripped vote sends the block back to learning
    p_relearn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_trip && uvlo_ok) |=> (ctl_q.ph == PH_LEARN));

    // R8: the mode moves only as learning hands over to checking
    p_mode_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.md != $past(ctl_q.md)) |-> ($past(ctl_q.ph) == PH_LEARN && ctl_q.ph == PH_CHECK));

endmodule

// File: tb/dimmer_classifier_bench.sv
module dimmer_classifier_bench;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       uvlo_ok = 1'b0;
    logic       cyc_stb = 1'b0;
    logic       rise_cut = 1'b0;
    logic       fall_steep = 1'b0;
    logic [1:0] mode;
    logic [1:0] phase;

    dimmer_classifier u_dimmer_classifier (
        .clk        (clk),
        .rst_n      (rst_n),
        .uvlo_ok    (uvlo_ok),
        .cyc_stb    (cyc_stb),
        .rise_cut   (rise_cut),
        .fall_steep (fall_steep),
        .mode       (mode),
        .phase      (phase)
    );

    typedef struct {
        int    due;
        int    ph;
        int    md;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;

    // expected-behaviour state, built from the requirements
    int m_ph = 0, m_md = 0, m_lcnt = 0, m_pc = 0, m_vote = 0;
    bit m_all_s = 1, m_all_r = 1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int ph, input int md);
        n_chk++;
        if (phase !== 2'(ph) || mode !== 2'(md)) begin
            n_fail++;
            $display("FAIL %s: phase=%0d mode=%0d expected phase=%0d mode=%0d",
                     tag, phase, mode, ph, md);
        end
    endtask

    // monitor: pop each expectation in the cycle it falls due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, e.ph, e.md);
        end
    end

    task automatic enter_learn();
        m_ph = 1; m_lcnt = 0; m_all_s = 1; m_all_r = 1;
    endtask

    // driver: one clock of stimulus, expected result pushed to the queue
    task automatic step(input bit uv, input bit stb, input bit s, input bit r, input string tag);
        @(negedge clk);
        uvlo_ok = uv; cyc_stb = stb; fall_steep = s; rise_cut = r;
        if (!uv) begin
            m_ph = 0;
        end else if (m_ph == 0) begin
            enter_learn();
        end else if (m_ph == 1) begin
            if (stb) begin
                m_all_s = m_all_s & s;
                m_all_r = m_all_r & r;
                if (m_lcnt == 1) begin
                    m_md = m_all_s ? 2 : (m_all_r ? 1 : 0);
                    m_ph = 2; m_pc = 0; m_vote = 0;
                end else begin
                    m_lcnt++;
                end
            end
        end else if (stb) begin
            if (m_pc == 15) begin
                int cls;
                m_pc = 0;
                cls = s ? 2 : (r ? 1 : 0);
                if (cls != m_md) begin
                    if (m_vote == 6) enter_learn();
                    else m_vote++;
                end else if (m_vote > 0) begin
                    m_vote--;
                end
            end else begin
                m_pc++;
            end
        end
        q.push_back('{cyc + 1, m_ph, m_md, tag});
    endtask

    // n line cycles, each a strobe clock followed by a quiet clock
    task automatic cycles(input int n, input bit s, input bit r, input string tag);
        for (int i = 0; i < n; i++) begin
            step(1, 1, s, r, tag);
            step(1, 0, 0, 0, tag);
        end
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!finished) begin
                    n_fail++;
                    n_chk++;
                    $display("FAIL watchdog: run did not end, expected completion");
                    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                    $finish;
                end
            end
        join_none

        repeat (4) @(negedge clk);
        check("R1 reset state", 0, 0);
        rst_n = 1'b1;

        // R2: no supply, strobes with flags do nothing
        for (int i = 0; i < 5; i++) step(0, 1, 1, 1, "R2 idle without supply");
        // R3: supply ready, learning starts
        step(1, 0, 0, 0, "R3 enter learn");
        // R4/R5: two steep strobes select trailing
        cycles(1, 1, 0, "R4 first learn strobe");
        cycles(1, 1, 0, "R5 trailing learned");
        // R6: matching checks keep the mode
        cycles(32, 1, 0, "R6 matching checks");
        // R7/R8: seven mismatching checks relearn, mode held
        cycles(112, 0, 1, "R7 R8 mismatch to relearn");
        cycles(2, 0, 1, "R5 leading learned");
        // R7: alternating periods, vote never reaches the limit
        for (int k = 0; k < 6; k++) begin
            cycles(16, 1, 0, "R7 noisy mismatch");
            cycles(16, 0, 1, "R7 match recovers");
        end
        // R7: six mismatches, one match, then two more trip it
        cycles(96, 0, 0, "R7 six mismatches");
        cycles(16, 0, 1, "R7 one match");
        cycles(32, 0, 0, "R7 reach limit");
        // R5: mixed evidence gives no dimmer
        cycles(1, 1, 0, "R5 mixed first");
        cycles(1, 0, 1, "R5 mixed none");
        // R2: supply loss in check phase, mode held
        step(0, 0, 0, 0, "R2 drop in check");
        step(0, 1, 1, 1, "R2 stay idle");
        step(1, 0, 0, 0, "R3 restart");
        cycles(2, 1, 1, "R5 both flags trailing wins");
        // R2/R4: supply loss mid-learn restarts the strobe count
        step(0, 0, 0, 0, "R2 drop before learn");
        step(1, 0, 0, 0, "R3 restart again");
        cycles(1, 1, 0, "R4 partial learn");
        step(0, 0, 0, 0, "R2 drop mid learn");
        step(1, 0, 0, 0, "R3 restart third");
        cycles(2, 0, 1, "R4 fresh learn leading");

        while (q.size() > 0) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule